// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between a core's execution pipeline and its cache. It holds stores the core has issued but memory has not yet seen. The core hands a store over in one cycle and carries on at once. The buffer then writes its entries to memory through a valid/ready write port, oldest first, at one entry per cycle whenever memory is ready. Until a store leaves the buffer, no other agent can see it.

A load from the same core looks up the pending entries in the same cycle. If one or more entries hold the load's address, the buffer returns the most recently accepted one. A load to any other address goes ahead of the older stores.

A fence is a level request from the core. It stays high until the buffer raises its done flag, which happens once every earlier store has been written out.
- A store fence holds back new stores while it is pending.
- A full fence also holds back loads while stores are still pending.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `mem_wr_valid` is 0, `st_ready` is 1, `ld_hit` is 0 and `ld_ready` is 1.
- R2: A store is taken in on every rising edge where `st_valid` and `st_ready` are both high. `st_ready` is 0 while `DEPTH` entries are held, and a store offered while full is dropped and never reaches memory.
- R3: The oldest entry is presented on `mem_wr_addr`/`mem_wr_data` with `mem_wr_valid` high. It is held stable until an edge with `mem_wr_ready` high. Entries leave in the order they were accepted, at most one per cycle.
- R4: With `ld_valid` high, `ld_hit` and `ld_data` respond in the same cycle. `ld_hit` is 1 when any pending entry has address `ld_addr`, and `ld_data` is then the data of the most recently accepted such entry.
- R5: A load whose address matches no pending entry gives `ld_hit` = 0. Without a full fence it is never held back (`ld_ready` = 1), even while older stores to other addresses are pending.
- R6: While `fence_req` is high (either kind), `st_ready` is 0. `fence_done` is 1 exactly when `fence_req` is high and the buffer is empty. Draining continues during a fence.
- R7: With `fence_kind` = 1 (full fence), `ld_ready` is 0 while `fence_req` is high and the buffer is not empty. With `fence_kind` = 0 (store fence), `ld_ready` stays 1.
- R8: A store can be accepted in the same cycle that an entry drains, so that the occupancy is unchanged and `st_ready` stays 1 through a back-to-back stream when memory is always ready.
- R9: An entry draining in the current cycle is still forwarded to a load in that cycle. In the cycle after it drains, that entry no longer hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core offers a store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Buffer can take the store this cycle |
| ld_valid | input | 1 | Core performs a load lookup |
| ld_addr | input | ADDR_W | Load address |
| ld_hit | output | 1 | A pending entry matches the load |
| ld_data | output | DATA_W | Forwarded data from the youngest match |
| ld_ready | output | 1 | Load may complete this cycle |
| fence_req | input | 1 | Fence pending, held until done |
| fence_kind | input | 1 | 0 = store fence, 1 = full fence |
| fence_done | output | 1 | All earlier stores are visible |
| mem_wr_valid | output | 1 | Oldest entry offered to memory |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |
| mem_wr_ready | input | 1 | Memory takes the write on this edge |

## Verification
Two functions can fall in the same cycle.

- **Enqueue and drain.** The bench keeps memory always ready and streams stores on consecutive cycles, so that each new store arrives on the edge where the previous one leaves. It judges the result by `st_ready` staying high and by the memory log holding every address in order.
- **Forwarding and draining.** A load to the oldest entry is issued in the very cycle memory first becomes ready. The bench expects a hit in that cycle and a miss in the next.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  typedef enum logic {
    FENCE_STORE = 1'b0,
    FENCE_FULL  = 1'b1
  } fence_kind_e;

endpackage

// File: rtl/tsb_queue.sv
module tsb_queue #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [ADDR_W-1:0]             push_addr,
  input  logic [DATA_W-1:0]             push_data,
  input  logic                          pop,
  output logic [ADDR_W-1:0]             head_addr,
  output logic [DATA_W-1:0]             head_data,
  output logic                          empty,
  output logic                          full,
  output logic [CNT_W-1:0]              count,
  output logic [PTR_W-1:0]              rd_ptr,
  output logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
  output logic [DEPTH-1:0][DATA_W-1:0]  slot_data
);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (int'(p) == DEPTH - 1) return '0;
    return p + 1'b1;
  endfunction

  logic [PTR_W-1:0] wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_addr[s] <= '0;
        slot_data[s] <= '0;
      end else if (push && int'(wr_ptr) == s) begin
        slot_addr[s] <= push_addr;
        slot_data[s] <= push_data;
      end
    end
  end

  assign empty     = (count == '0);
  assign full      = (int'(count) == DEPTH);
  assign head_addr = slot_addr[rd_ptr];
  assign head_data = slot_data[rd_ptr];

endmodule

// File: rtl/tsb_fwd_match.sv
module tsb_fwd_match #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          ld_valid,
  input  logic [ADDR_W-1:0]             ld_addr,
  input  logic [PTR_W-1:0]              rd_ptr,
  input  logic [CNT_W-1:0]              count,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
  output logic                          hit,
  output logic [DATA_W-1:0]             data
);

  // Physical slot holding the entry that is 'age' places behind the oldest.
  function automatic int slot_of_age(input int head, input int age);
    return (head + age) % DEPTH;
  endfunction

  always_comb begin
    hit  = 1'b0;
    data = '0;
    // Scan oldest to youngest; later matches override, so the youngest wins.
    for (int age = 0; age < DEPTH; age++) begin
      if (ld_valid && age < int'(count) &&
          slot_addr[slot_of_age(int'(rd_ptr), age)] == ld_addr) begin
        hit  = 1'b1;
        data = slot_data[slot_of_age(int'(rd_ptr), age)];
      end
    end
  end

endmodule

// File: rtl/tsb_fence_ctl.sv
module tsb_fence_ctl
  import tsb_pkg::*;
(
  input  logic fence_req,
  input  logic fence_kind,
  input  logic empty,
  input  logic full,
  output logic st_ready,
  output logic ld_ready,
  output logic fence_done
);

  fence_kind_e kind;

  always_comb begin
    kind       = fence_kind_e'(fence_kind);
    st_ready   = !full && !fence_req;
    ld_ready   = !(fence_req && kind == FENCE_FULL && !empty);
    fence_done = fence_req && empty;
  end

endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_ready,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_ready,
  input  logic              fence_req,
  input  logic              fence_kind,
  output logic              fence_done,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ready
);

  // Named internal events, brought out for the checker.
  logic                         push_fire;
  logic                         pop_fire;
  logic                         q_empty;
  logic                         q_full;
  logic [CNT_W-1:0]             occupancy;
  logic [PTR_W-1:0]             head_ptr;
  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
  logic [DEPTH-1:0][DATA_W-1:0] slot_data;

  assign push_fire    = st_valid && st_ready;
  assign mem_wr_valid = !q_empty;
  assign pop_fire     = mem_wr_valid && mem_wr_ready;

  tsb_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) queue_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_fire),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (pop_fire),
    .head_addr (mem_wr_addr),
    .head_data (mem_wr_data),
    .empty     (q_empty),
    .full      (q_full),
    .count     (occupancy),
    .rd_ptr    (head_ptr),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  tsb_fwd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) match_i (
    .ld_valid  (ld_valid),
    .ld_addr   (ld_addr),
    .rd_ptr    (head_ptr),
    .count     (occupancy),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .hit       (ld_hit),
    .data      (ld_data)
  );

  tsb_fence_ctl fence_i (
    .fence_req  (fence_req),
    .fence_kind (fence_kind),
    .empty      (q_empty),
    .full       (q_full),
    .st_ready   (st_ready),
    .ld_ready   (ld_ready),
    .fence_done (fence_done)
  );

endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_ready,
  input logic              ld_valid,
  input logic              ld_hit,
  input logic              ld_ready,
  input logic              fence_req,
  input logic              fence_kind,
  input logic              fence_done,
  input logic              mem_wr_valid,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_wr_ready,
  input logic              push_fire,
  input logic              pop_fire,
  input logic [CNT_W-1:0]  occupancy
);

  // R2
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) == DEPTH |-> !st_ready);

  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=>
      mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R4
  hit_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> ld_valid && occupancy != '0);

  // R6
  fence_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> !mem_wr_valid && occupancy == '0);

  // R7
  full_fence_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req && fence_kind && mem_wr_valid |-> !ld_ready);

  // R8
  occ_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
      int'(occupancy) == int'($past(occupancy)) + int'($past(push_fire))
                         - int'($past(pop_fire)));

endmodule

bind tso_store_buffer tsb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_ready     (st_ready),
  .ld_valid     (ld_valid),
  .ld_hit       (ld_hit),
  .ld_ready     (ld_ready),
  .fence_req    (fence_req),
  .fence_kind   (fence_kind),
  .fence_done   (fence_done),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .mem_wr_ready (mem_wr_ready),
  .push_fire    (push_fire),
  .pop_fire     (pop_fire),
  .occupancy    (occupancy)
);

// File: tb/tso_store_buffer_tb_top.sv
module tso_store_buffer_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_ready;
  logic          ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic          ld_hit;
  logic [DW-1:0] ld_data;
  logic          ld_ready;
  logic          fence_req = 1'b0;
  logic          fence_kind = 1'b0;
  logic          fence_done;
  logic          mem_wr_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          mem_wr_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [AW-1:0] log_addr [0:63];
  logic [DW-1:0] log_data [0:63];
  int log_n = 0;

  always #2.5 clk = ~clk;

  tso_store_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .ld_ready(ld_ready),
    .fence_req(fence_req), .fence_kind(fence_kind), .fence_done(fence_done),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ready(mem_wr_ready)
  );

  // Memory model: record every write taken on an edge.
  always @(posedge clk) begin
    if (rst_n && mem_wr_valid && mem_wr_ready && log_n < 64) begin
      log_addr[log_n] = mem_wr_addr;
      log_data[log_n] = mem_wr_data;
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk(st_ready == 1'b1 && mem_wr_valid == 1'b0 && ld_hit == 1'b0 && ld_ready == 1'b1,
        "R1 reset state", {st_ready, mem_wr_valid, ld_hit, ld_ready}, 4'b1001);
  endtask

  task automatic t_fill_and_drain;
    mem_wr_ready = 1'b0;
    log_n = 0;
    for (int i = 0; i < DEPTH; i++) push(AW'(16'h40 + i), DW'(32'hA000 + i));
    #1;
    chk(st_ready == 1'b0, "R2 full refuses", st_ready, 0);
    push(16'h55, 32'hDEAD);  // dropped while full
    @(negedge clk);
    mem_wr_ready = 1'b1;
    idle(DEPTH + 3);
    mem_wr_ready = 1'b0;
    chk(log_n == DEPTH, "R2 R3 drained count", log_n, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      chk(log_addr[i] == AW'(16'h40 + i) && log_data[i] == DW'(32'hA000 + i),
          "R3 drain order", log_addr[i], 16'h40 + i);
  endtask

  task automatic t_forward;
    mem_wr_ready = 1'b0;
    push(16'h10, 32'h1);
    push(16'h20, 32'h2);
    push(16'h10, 32'h3);
    ld_valid = 1'b1; ld_addr = 16'h10;
    #1;
    chk(ld_hit == 1'b1 && ld_data == 32'h3, "R4 youngest forwarded", ld_data, 32'h3);
    ld_addr = 16'h20;
    #1;
    chk(ld_hit == 1'b1 && ld_data == 32'h2, "R4 single match", ld_data, 32'h2);
    ld_addr = 16'h30;
    #1;
    chk(ld_hit == 1'b0 && ld_ready == 1'b1, "R5 miss passes stores", {ld_hit, ld_ready}, 2'b01);
    ld_valid = 1'b0;
    @(negedge clk);
    mem_wr_ready = 1'b1;
    idle(5);
    mem_wr_ready = 1'b0;
  endtask

  task automatic t_fence(input bit full_kind);
    mem_wr_ready = 1'b0;
    push(16'h60, 32'h6);
    push(16'h61, 32'h7);
    @(negedge clk);
    fence_req = 1'b1; fence_kind = full_kind;
    #1;
    chk(st_ready == 1'b0 && fence_done == 1'b0, "R6 fence pending",
        {st_ready, fence_done}, 2'b00);
    if (full_kind)
      chk(ld_ready == 1'b0, "R7 full fence holds loads", ld_ready, 0);
    else
      chk(ld_ready == 1'b1, "R7 store fence lets loads go", ld_ready, 1);
    @(negedge clk);
    mem_wr_ready = 1'b1;
    idle(4);
    #1;
    chk(fence_done == 1'b1 && ld_ready == 1'b1 && st_ready == 1'b0,
        "R6 fence done after drain", {fence_done, ld_ready, st_ready}, 3'b110);
    @(negedge clk);
    fence_req = 1'b0;
    mem_wr_ready = 1'b0;
    #1;
    chk(st_ready == 1'b1 && fence_done == 1'b0, "R6 fence released",
        {st_ready, fence_done}, 2'b10);
  endtask

  task automatic t_stream;
    bit all_ready = 1'b1;
    mem_wr_ready = 1'b1;
    log_n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      st_valid = 1'b1; st_addr = AW'(16'h100 + i); st_data = DW'(32'hB0 + i);
      #1;
      if (!st_ready) all_ready = 1'b0;
    end
    @(negedge clk);
    st_valid = 1'b0;
    idle(3);
    chk(all_ready, "R8 ready through stream", all_ready, 1);
    chk(log_n == 3 && log_addr[0] == 16'h100 && log_addr[2] == 16'h102,
        "R8 stream drained in order", log_n, 3);
    mem_wr_ready = 1'b0;
  endtask

  task automatic t_forward_while_drain;
    mem_wr_ready = 1'b0;
    push(16'h77, 32'hAB);
    @(negedge clk);
    mem_wr_ready = 1'b1; ld_valid = 1'b1; ld_addr = 16'h77;
    #1;
    chk(ld_hit == 1'b1 && ld_data == 32'hAB && mem_wr_valid == 1'b1,
        "R9 hit in drain cycle", ld_data, 32'hAB);
    @(negedge clk);
    #1;
    chk(ld_hit == 1'b0 && mem_wr_valid == 1'b0, "R9 miss after drain", ld_hit, 0);
    ld_valid = 1'b0;
    mem_wr_ready = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_fill_and_drain();
    t_forward();
    t_fence(1'b0);
    t_fence(1'b1);
    t_stream();
    t_forward_while_drain();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule